// File: doc/BRIEF.md
# Memory-Driven Trigger Sequencer

The block produces timed trigger pulses after each reload event. A counter restarts at zero on reload. The block walks a list of 16-bit delay values held in memory. It reads each value byte by byte through a simple read port and raises a one-cycle trigger when the counter reaches the value. A zero value ends the list.

Two errors stop the list until the next reload: a value that breaks ascending order, and a value that arrives too late to be reached. Either error sets a sticky flag.

Software sets up a base pointer and two list start indices through a small register port. All reads fall inside a 256-byte window above the base pointer. The `listSel` input picks the list at each reload. While the generator is enabled, the pointer and index registers are locked.

Top module: `trig_seq`

## Requirements
- R1: After reset, `trigOut`, `memRdReq` and `errFlag` are 0, and every register reads back 0.
- R2: While the enable bit (register 3, bit 0) is 0, there are no triggers and no memory reads, even when `reload` pulses.
- R3: Writes to the base pointer (register 0) and to the list start indices (registers 1 and 2) are ignored while enable is 1, and accepted while it is 0. Register reads return the stored values.
- R4: For entry n of a list with start index S, the high byte is read at base + ((S + 2n) mod 256) and the low byte at base + ((S + 2n + 1) mod 256). A read address is never outside base .. base+255.
- R5: An entry of value D produces a trigger pulse exactly one clock wide. The pulse falls in the cycle that begins D clock edges after the edge that samples `reload`.
- R6: The `listSel` value sampled with `reload` selects the start index: 0 selects register 1, and 1 selects register 2.
- R7: An entry of 0x0000 ends the list. After it, there are no triggers and no reads until the next reload.
- R8: An entry smaller than the previous entry of the same list sets `errFlag`. It also stops all triggers and reads until the next reload.
- R9: An entry that is not greater than the counter value in the cycle its low byte is accepted sets `errFlag` and stops the list. When every read is granted at once, the first entry must therefore be at least 2, and each later entry must exceed the previous one by at least 3.
- R10: `errFlag` is sticky, including across reloads. Writing register 3 with bit 1 set clears it. A new error in the same cycle wins over the clear.
- R11: A reload restarts the counter at zero and restarts the selected list from its first entry. This holds when the list is stopped in error and when the list is midway through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 base, 1 list-0 index, 2 list-1 index, 3 control |
| regWdata | input | ADDR_W | Register write data |
| regRdata | output | ADDR_W | Read data of the register chosen by regAddr; control reads {err, enable} in bits 1:0 |
| reload | input | 1 | Reload event, one cycle |
| listSel | input | 1 | List chosen at reload |
| memRdReq | output | 1 | Read request; a byte transfers in each cycle where both req and valid are high |
| memRdAddr | output | ADDR_W | Byte read address |
| memRdValid | input | 1 | Read grant; memRdData is valid in this cycle |
| memRdData | input | BYTE_W | Read data byte |
| trigOut | output | 1 | Trigger pulse |
| errFlag | output | 1 | Sticky list error flag |

## Verification
The bench builds the block with ADDR_W = 10, so a 1024-byte memory model covers the whole address space. BYTE_W keeps its default of 8, so entries are 16 bits and counts stay small enough to reach every ordering and lateness boundary within a few hundred cycles.

With a base pointer of 0x100, a start index of 0xFE places an entry across the window's wrap point. A decoy value placed just above the window exposes any read that escapes the window.

Randomly stalled read grants are used only on lists with wide gaps. This checks that stalls delay fetches without moving trigger times.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_HI,
    ST_FETCH_LO,
    ST_ARMED,
    ST_DONE,
    ST_FAULT
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic run;        // counter may advance
    logic restart;    // accepted reload
    logic hiLoad;     // capture high byte
    logic byteAdv;    // step window offset
    logic entryLoad;  // accept assembled entry
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic newZero;    // assembled value is the end marker
    logic newBad;     // out of order or too late
    logic hit;        // counter equals armed entry
  } dpFlag_t;

endpackage

// File: rtl/trig_seq_regs.sv
module trig_seq_regs #(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              errSet,
  output logic [ADDR_W-1:0] regRdata,
  output logic [ADDR_W-1:0] basePtr,
  output logic [WIN_W-1:0]  idx0,
  output logic [WIN_W-1:0]  idx1,
  output logic              enable,
  output logic              errFlag
);

  logic errClr;
  assign errClr = regWe && (regAddr == 2'd3) && regWdata[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      basePtr <= '0;
      idx0    <= '0;
      idx1    <= '0;
      enable  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (regWe) begin
        case (regAddr)
          2'd0:    if (!enable) basePtr <= regWdata;
          2'd1:    if (!enable) idx0 <= regWdata[WIN_W-1:0];
          2'd2:    if (!enable) idx1 <= regWdata[WIN_W-1:0];
          default: enable <= regWdata[0];
        endcase
      end
      if (errSet)      errFlag <= 1'b1;
      else if (errClr) errFlag <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = basePtr;
      2'd1:    regRdata = ADDR_W'(idx0);
      2'd2:    regRdata = ADDR_W'(idx1);
      default: regRdata = ADDR_W'({errFlag, enable});
    endcase
  end

endmodule

// File: rtl/trig_seq_dp.sv
module trig_seq_dp
  import trig_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int WIN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              listSel,
  input  logic [ADDR_W-1:0] basePtr,
  input  logic [WIN_W-1:0]  idx0,
  input  logic [WIN_W-1:0]  idx1,
  input  logic [BYTE_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output dpFlag_t           flags
);

  localparam int ENTRY_W = 2 * BYTE_W;

  logic [ENTRY_W-1:0] cnt, curEntry, prevEntry, newVal;
  logic [WIN_W-1:0]   offset;
  logic [BYTE_W-1:0]  hiByte;

  assign newVal = {hiByte, memRdData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      offset    <= '0;
      hiByte    <= '0;
      curEntry  <= '0;
      prevEntry <= '0;
    end else begin
      // saturating counter, cleared while stopped or on reload
      if (!strobe.run || strobe.restart) cnt <= '0;
      else if (cnt != '1)                cnt <= cnt + 1'b1;

      if (strobe.restart)      offset <= listSel ? idx1 : idx0;
      else if (strobe.byteAdv) offset <= offset + 1'b1;

      if (strobe.hiLoad) hiByte <= memRdData;

      if (strobe.restart) begin
        prevEntry <= '0;
      end else if (strobe.entryLoad) begin
        prevEntry <= newVal;
        curEntry  <= newVal;
      end
    end
  end

  assign memRdAddr     = basePtr + ADDR_W'(offset);
  assign flags.newZero = (newVal == '0);
  assign flags.newBad  = (newVal < prevEntry) || (newVal <= cnt);
  assign flags.hit     = (cnt == curEntry);

endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      reload,
  input  logic      memRdValid,
  input  dpFlag_t   flags,
  output dpStrobe_t strobe,
  output logic      memRdReq,
  output logic      trigOut,
  output logic      errSet
);

  seqState_t state, nextState;
  logic live, xfer, loDone;

  assign live     = enable && !reload;
  assign memRdReq = enable && (state == ST_FETCH_HI || state == ST_FETCH_LO);
  assign xfer     = memRdReq && memRdValid && !reload;
  assign loDone   = xfer && (state == ST_FETCH_LO);

  always_comb begin
    strobe.run       = enable;
    strobe.restart   = enable && reload;
    strobe.hiLoad    = xfer && (state == ST_FETCH_HI);
    strobe.byteAdv   = xfer;
    strobe.entryLoad = loDone && !flags.newZero && !flags.newBad;
    errSet           = loDone && !flags.newZero && flags.newBad;
    trigOut          = live && (state == ST_ARMED) && flags.hit;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_FETCH_HI: if (xfer) nextState = ST_FETCH_LO;
      ST_FETCH_LO: if (loDone)
                     nextState = flags.newZero ? ST_DONE :
                                 flags.newBad  ? ST_FAULT : ST_ARMED;
      ST_ARMED:    if (trigOut) nextState = ST_FETCH_HI;
      default:     nextState = state;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= ST_IDLE;
    else if (!enable) state <= ST_IDLE;
    else if (reload)  state <= ST_FETCH_HI;
    else              state <= nextState;
  end

endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic              reload,
  input  logic              listSel,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [BYTE_W-1:0] memRdData,
  output logic              trigOut,
  output logic              errFlag
);

  localparam int WIN_W = $clog2(WIN_BYTES);

  dpStrobe_t         strobe;
  dpFlag_t           flags;
  logic [ADDR_W-1:0] basePtr;
  logic [WIN_W-1:0]  idx0, idx1;
  logic              enable, errSet;

  trig_seq_regs #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) uRegs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .errSet(errSet), .regRdata(regRdata),
    .basePtr(basePtr), .idx0(idx0), .idx1(idx1),
    .enable(enable), .errFlag(errFlag)
  );

  trig_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .reload(reload),
    .memRdValid(memRdValid), .flags(flags), .strobe(strobe),
    .memRdReq(memRdReq), .trigOut(trigOut), .errSet(errSet)
  );

  trig_seq_dp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WIN_W(WIN_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .listSel(listSel),
    .basePtr(basePtr), .idx0(idx0), .idx1(idx1),
    .memRdData(memRdData), .memRdAddr(memRdAddr), .flags(flags)
  );

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              trigOut,
  input logic              memRdReq,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic [ADDR_W-1:0] basePtr,
  input logic              errFlag,
  input logic              errClr
);

  logic [ADDR_W-1:0] winOff;
  assign winOff = memRdAddr - basePtr;

  assert_quiet_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!trigOut && !memRdReq));

  assert_base_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> (basePtr == $past(basePtr)));

  assert_in_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> (winOff < ADDR_W'(1 << WIN_W)));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

endmodule

bind trig_seq trig_seq_chk #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .trigOut(trigOut),
  .memRdReq(memRdReq), .memRdAddr(memRdAddr), .basePtr(basePtr),
  .errFlag(errFlag),
  .errClr(regWe && (regAddr == 2'd3) && regWdata[1])
);

// File: tb/sim_trig_seq.sv
module sim_trig_seq;

  localparam int AW   = 10;
  localparam int BASE = 'h100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [AW-1:0] regWdata = '0;
  logic [AW-1:0] regRdata;
  logic          reload = 1'b0, listSel = 1'b0;
  logic          memRdReq, memRdValid = 1'b1;
  logic [AW-1:0] memRdAddr;
  logic [7:0]    memRdData;
  logic          trigOut, errFlag;
  logic [7:0]    mem [0:(1<<AW)-1];
  bit            stallOn = 1'b0;
  int            nChecks = 0, nFail = 0;

  trig_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .reload(reload),
    .listSel(listSel), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdValid(memRdValid), .memRdData(memRdData),
    .trigOut(trigOut), .errFlag(errFlag)
  );

  always #5 clk = ~clk;
  assign memRdData = mem[memRdAddr];

  always @(negedge clk) memRdValid = stallOn ? (($urandom % 4) != 0) : 1'b1;

  // window monitor (R4)
  int winBad = 0;
  always @(negedge clk)
    if (rstN && memRdReq && (((memRdAddr - AW'(BASE)) & AW'('h3FF)) > AW'(255))) winBad++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(input int a, input int d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 2'(a); regWdata = AW'(d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input int a, output int d);
    regAddr = 2'(a);
    #1 d = int'(regRdata);
  endtask

  task automatic setIdx(input int which, input int val);
    regWrite(3, 0);
    regWrite(1 + which, val);
    regWrite(3, 1);
  endtask

  task automatic putList(input int off, input int n, input int vals[8]);
    for (int i = 0; i < n; i++) begin
      mem[BASE + ((off + 2*i) & 255)]     = 8'(vals[i] >> 8);
      mem[BASE + ((off + 2*i + 1) & 255)] = 8'(vals[i]);
    end
  endtask

  // expected triggers with every read granted at once (R5, R7, R8, R9)
  function automatic void expectList(input int off, output int n, output int ev[32], output bit err);
    int c = 1, prev = 0, o = off, v;
    n = 0; err = 0;
    for (int i = 0; i < 30; i++) begin
      v = {mem[BASE + o], mem[BASE + ((o + 1) & 255)]};
      o = (o + 2) & 255;
      if (v == 0) break;
      if (v < prev || v <= c) begin err = 1; break; end
      ev[n] = v; n++; prev = v; c = v + 2;
    end
  endfunction

  task automatic runCapture(input bit sel, input int cycles, output int n,
                            output int tt[32], output int lastReq, output int dbl);
    @(negedge clk);
    listSel = sel; reload = 1'b1;
    @(negedge clk);
    reload = 1'b0;
    n = 0; lastReq = -1; dbl = 0;
    for (int k = 0; k < cycles; k++) begin
      if (k > 0) @(negedge clk);
      if (trigOut) begin
        if (n > 0 && tt[n-1] == k - 1) dbl++;
        if (n < 32) tt[n] = k;
        n++;
      end
      if (memRdReq) lastReq = k;
    end
  endtask

  task automatic cmpList(input string tag, input int n, input int tt[32], input int en, input int ev[32]);
    bit ok = (n == en);
    int a = n, e = en;
    for (int i = 0; i < en && i < 32; i++)
      if (ok && tt[i] != ev[i]) begin ok = 0; a = tt[i]; e = ev[i]; end
    check(ok, tag, a, e);
  endtask

  initial begin
    #(10 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int d, n, en, lastReq, dbl, tt[32], ev[32];
    bit eErr;
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!trigOut && !memRdReq, "R1 outputs idle", int'(trigOut), 0);
    check(!errFlag, "R1 err clear", int'(errFlag), 0);
    regRead(0, d); check(d == 0, "R1 base reads 0", d, 0);
    regRead(3, d); check(d == 0, "R1 ctrl reads 0", d, 0);

    // R3 writes accepted while disabled
    regWrite(0, BASE); regWrite(1, 'h10); regWrite(2, 'h80);
    regRead(0, d); check(d == BASE, "R3 base accepted", d, BASE);
    regRead(2, d); check(d == 'h80, "R3 idx1 accepted", d, 'h80);

    // R2 disabled: reload does nothing
    putList('h10, 2, '{5, 0, 0, 0, 0, 0, 0, 0});
    runCapture(0, 40, n, tt, lastReq, dbl);
    check(n == 0 && lastReq < 0, "R2 no activity while disabled", n + lastReq + 1, 0);

    // R3 lock while enabled
    regWrite(3, 1);
    regWrite(0, 'h200); regWrite(1, 'h55);
    regRead(0, d); check(d == BASE, "R3 base locked", d, BASE);
    regRead(1, d); check(d == 'h10, "R3 idx0 locked", d, 'h10);

    // R5 R7 basic list
    putList('h10, 4, '{5, 9, 20, 0, 0, 0, 0, 0});
    runCapture(0, 60, n, tt, lastReq, dbl);
    ev[0] = 5; ev[1] = 9; ev[2] = 20;
    cmpList("R5 trigger times", n, tt, 3, ev);
    check(dbl == 0, "R5 one-cycle pulse", dbl, 0);
    check(lastReq <= 23, "R7 no reads after end marker", lastReq, 23);
    check(!errFlag, "R7 no error", int'(errFlag), 0);

    // R6 second list
    putList('h80, 3, '{30, 100, 0, 0, 0, 0, 0, 0});
    runCapture(1, 130, n, tt, lastReq, dbl);
    ev[0] = 30; ev[1] = 100;
    cmpList("R6 list 1 selected", n, tt, 2, ev);

    // R4 wrap inside window, decoy just above it
    setIdx(0, 'hFE);
    putList('hFE, 3, '{12, 40, 0, 0, 0, 0, 0, 0});
    mem[BASE + 256] = 8'h00; mem[BASE + 257] = 8'h00;
    runCapture(0, 70, n, tt, lastReq, dbl);
    ev[0] = 12; ev[1] = 40;
    cmpList("R4 offset wraps in window", n, tt, 2, ev);
    setIdx(0, 'h10);

    // R8 descending
    putList('h10, 5, '{10, 30, 25, 60, 0, 0, 0, 0});
    runCapture(0, 100, n, tt, lastReq, dbl);
    ev[0] = 10; ev[1] = 30;
    cmpList("R8 stops at descending entry", n, tt, 2, ev);
    check(errFlag, "R8 err set", int'(errFlag), 1);
    check(lastReq <= 32, "R8 reads stop", lastReq, 32);

    // R11 restart from error, R10 sticky across reload
    putList('h80, 2, '{15, 0, 0, 0, 0, 0, 0, 0});
    runCapture(1, 40, n, tt, lastReq, dbl);
    ev[0] = 15;
    cmpList("R11 restart after error", n, tt, 1, ev);
    check(errFlag, "R10 err sticky", int'(errFlag), 1);
    regWrite(3, 3);
    check(!errFlag, "R10 write-1 clears", int'(errFlag), 0);
    regRead(3, d); check(d == 1, "R10 enable kept", d, 1);

    // R9 late entries
    putList('h10, 2, '{1, 0, 0, 0, 0, 0, 0, 0});
    runCapture(0, 20, n, tt, lastReq, dbl);
    check(n == 0 && errFlag, "R9 first entry 1 late", n, 0);
    regWrite(3, 3);
    putList('h10, 3, '{10, 12, 0, 0, 0, 0, 0, 0});
    runCapture(0, 40, n, tt, lastReq, dbl);
    ev[0] = 10;
    cmpList("R9 gap of 2 late", n, tt, 1, ev);
    check(errFlag, "R9 err on gap 2", int'(errFlag), 1);
    regWrite(3, 3);
    putList('h10, 3, '{10, 13, 0, 0, 0, 0, 0, 0});
    runCapture(0, 40, n, tt, lastReq, dbl);
    ev[0] = 10; ev[1] = 13;
    cmpList("R9 gap of 3 accepted", n, tt, 2, ev);
    check(!errFlag, "R9 no err on gap 3", int'(errFlag), 0);
    putList('h10, 2, '{2, 0, 0, 0, 0, 0, 0, 0});
    runCapture(0, 20, n, tt, lastReq, dbl);
    ev[0] = 2;
    cmpList("R9 first entry 2 accepted", n, tt, 1, ev);

    // R11 mid-list reload
    putList('h10, 3, '{20, 50, 0, 0, 0, 0, 0, 0});
    runCapture(0, 30, n, tt, lastReq, dbl);
    runCapture(0, 70, n, tt, lastReq, dbl);
    ev[0] = 20; ev[1] = 50;
    cmpList("R11 mid-list reload restarts", n, tt, 2, ev);

    // R2 disable mid-run
    @(negedge clk); listSel = 0; reload = 1;
    @(negedge clk); reload = 0;
    regWrite(3, 0);
    d = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (trigOut || memRdReq) d++;
    end
    check(d == 0, "R2 quiet after disable", d, 0);
    regWrite(3, 1);

    // random lists with stalled grants
    for (int it = 0; it < 6; it++) begin
      int off = $urandom % 256, sel = $urandom % 2, cnt = 1 + $urandom % 4, t = 0;
      int vals[8];
      for (int i = 0; i < 8; i++) vals[i] = 0;
      for (int i = 0; i < cnt; i++) begin t += 40 + $urandom % 40; vals[i] = t; end
      putList(off, cnt + 1, vals);
      setIdx(sel, off);
      stallOn = 1;
      runCapture(sel[0], t + 30, n, tt, lastReq, dbl);
      stallOn = 0;
      expectList(off, en, ev, eErr);
      cmpList("R5 random list with stalls", n, tt, en, ev);
    end
    check(winBad == 0, "R4 reads inside window", winBad, 0);
    check(!errFlag, "R9 no spurious error", int'(errFlag), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule